// File: doc/BRIEF.md
# Multi-channel line-event interrupt controller

This block gathers status-change events from four telephone-line channels and folds them into one interrupt pin. Each channel presents raw status levels: hook, ring-trip, ground-key, ground-key polarity, over-temperature, ramp-done, tone-detect-done, level-meter-done and four debounced general IO bits. The block compares every level with a registered copy of itself. Some sources record a pending bit on any change and others only on a rising edge. Hook/ring-trip and ground-key results go to one shared global pending register. The remaining sources go to per-channel local pending registers.

Software reaches the block through a simple synchronous register port. Read data returns one cycle after the strobe, and reading a pending register empties it. Writing the global register with any value empties every pending register. Each channel has its own mask registers and its own soft reset. A single configuration bit sets whether the pin is active low or active high.

The read port is run by a two-state machine. BUS_IDLE moves to BUS_RESP on a read strobe (transition T_READ). BUS_RESP stays in BUS_RESP while strobes continue back to back (T_NEXT). BUS_RESP returns to BUS_IDLE when no strobe is present (T_DONE). Read data is valid only in BUS_RESP.

Top module: `line_irq_ctrl`

## Requirements
- R1: After hardware reset all pending registers read 0, both mask registers of each channel read all ones (0x1F event mask, 0x0F IO mask), the configuration register reads 0, bus_rvalid is 0 and irq_pin is 1 (inactive, active-low).
- R2: Register 0x00 is the global pending register. Bit c is set by any change, in either direction, of hook or ring-trip of channel c. Bit 4+c is set by any change of ground-key of channel c.
- R3: Register 0x10+4c is the local event pending register of channel c. Bit 0 (polarity) is set on any change. Bit 1 (over-temperature), bit 2 (ramp-done), bit 3 (tone-done) and bit 4 (level-meter-done) are set only on a 0-to-1 transition.
- R4: Register 0x11+4c bit n is set by any change of IO bit n of channel c (input st_io bit 4c+n), but only while io_is_in bit 4c+n is 1.
- R5: Mask register 0x12+4c has bit 0 for hook/ring-trip, bit 1 for ground-key, bit 2 for polarity, bit 3 for over-temperature and bit 4 for ramp. Mask register 0x13+4c bit n covers IO bit n. A 1 keeps a pending bit from driving the pin, but the bit is still recorded. Tone-done and level-meter-done cannot be masked.
- R6: Register 0x01 bit 0 selects the pin polarity: 0 means active low and 1 means active high. The pin is active exactly when some unmasked pending bit is set.
- R7: A read strobe returns the addressed register on bus_rdata with bus_rvalid high in the next cycle. The read clears the pending register it addressed. An event that arrives in the same cycle as that clear stays pending.
- R8: Any write to address 0x00 clears every global and local pending bit, so the pin returns to its inactive level.
- R9: A soft reset pulse on ch_srst bit c clears only channel c's local pending registers. Other channels and the global register are untouched. Status levels that are held steady during and after the pulse raise no event.
- R10: Status inputs that are already 1 when reset is released raise no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| st_hook | input | 4 | Hook status, one bit per channel |
| st_rtrip | input | 4 | Ring-trip status per channel |
| st_gkey | input | 4 | Ground-key status per channel |
| st_gpol | input | 4 | Ground-key polarity status per channel |
| st_otemp | input | 4 | Over-temperature status per channel |
| st_ramp | input | 4 | Ramp-done status per channel |
| st_tone | input | 4 | Tone-detect-done status per channel |
| st_lvl | input | 4 | Level-meter-done status per channel |
| st_io | input | 16 | Debounced IO bits, bit 4c+n is IO n of channel c |
| io_is_in | input | 16 | 1 marks the matching IO bit as an input |
| ch_srst | input | 4 | Per-channel soft reset pulse |
| bus_addr | input | 6 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq_pin | output | 1 | Interrupt output, polarity set by register 0x01 |

## Verification
The bench toggles each source in both directions. A design that treated every source alike would either record the falling edges of the over-temperature and level-meter bits or miss the release of hook and ground-key. It holds some status levels high through reset and through a soft reset, where a badly primed edge register would raise spurious events. It lines a new ground-key event up with a clear-on-read of the same register, where a clear that wins would drop the event silently. It also checks that one soft reset leaves other channels and the global register alone, and that a masked source still records its pending bit and drives the pin once it is unmasked.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
    localparam int A_GPEND = 0;
    localparam int A_CFG   = 1;
    localparam int CH_BASE = 16;
    localparam int NEV     = 5;
    localparam int DW      = 8;

    typedef enum logic {
        BUS_IDLE,
        BUS_RESP
    } bus_st_e;
endpackage

// File: rtl/lirq_bus_fsm.sv
module lirq_bus_fsm
    import lirq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [DW-1:0] rd_word,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    bus_st_e st_q, st_d;
    logic [DW-1:0] data_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BUS_IDLE: if (rd_en) st_d = BUS_RESP;
            BUS_RESP: st_d = rd_en ? BUS_RESP : BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= BUS_IDLE;
            data_q <= '0;
        end else begin
            st_q <= st_d;
            if (rd_en) data_q <= rd_word;
        end
    end

    always_comb begin
        rd_valid = (st_q == BUS_RESP);
        rd_data  = rd_valid ? data_q : '0;
    end
endmodule

// File: rtl/lirq_chan.sv
module lirq_chan
    import lirq_pkg::*;
#(
    parameter int NIO = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           srst,
    input  logic           clr_all,
    input  logic           s_hook,
    input  logic           s_rtrip,
    input  logic           s_gkey,
    input  logic           s_gpol,
    input  logic           s_otemp,
    input  logic           s_ramp,
    input  logic           s_tone,
    input  logic           s_lvl,
    input  logic [NIO-1:0] s_io,
    input  logic [NIO-1:0] io_in,
    input  logic           rdclr_ev,
    input  logic           rdclr_io,
    input  logic           wr_mev,
    input  logic           wr_mio,
    input  logic [DW-1:0]  wdata,
    output logic           ev_hk,
    output logic           ev_gk,
    output logic           ev_loc,
    output logic [NEV-1:0] lp_ev,
    output logic [NEV-1:0] mask_ev,
    output logic [NIO-1:0] lp_io,
    output logic [NIO-1:0] mask_io,
    output logic           irq_loc
);
    localparam int NST = 8;

    logic           primed;
    logic [NST-1:0] cur_s, prev_s, chg, rise;
    logic [NIO-1:0] prev_io, set_io;
    logic [NEV-1:0] set_ev, eff_mask;
    logic           live;

    assign cur_s = {s_lvl, s_tone, s_ramp, s_otemp, s_gpol, s_gkey, s_rtrip, s_hook};
    assign live  = primed && !srst;
    assign chg   = live ? (cur_s ^ prev_s) : '0;
    assign rise  = live ? (cur_s & ~prev_s) : '0;
    assign set_io = live ? ((s_io ^ prev_io) & io_in) : '0;

    assign ev_hk  = chg[0] | chg[1];
    assign ev_gk  = chg[2];
    assign set_ev = {rise[7], rise[6], rise[5], rise[4], chg[3]};
    assign ev_loc = (|set_ev) | (|set_io);

    // tone and level-meter bits have no mask
    assign eff_mask = {2'b00, mask_ev[4:2]};
    assign irq_loc  = (|(lp_ev & ~eff_mask)) | (|(lp_io & ~mask_io));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            primed  <= 1'b0;
            prev_s  <= '0;
            prev_io <= '0;
            lp_ev   <= '0;
            lp_io   <= '0;
            mask_ev <= '1;
            mask_io <= '1;
        end else begin
            primed  <= !srst;
            prev_s  <= cur_s;
            prev_io <= s_io;
            if (srst) begin
                lp_ev <= '0;
                lp_io <= '0;
            end else begin
                lp_ev <= (lp_ev & ~{NEV{rdclr_ev | clr_all}}) | set_ev;
                lp_io <= (lp_io & ~{NIO{rdclr_io | clr_all}}) | set_io;
            end
            if (wr_mev) mask_ev <= wdata[NEV-1:0];
            if (wr_mio) mask_io <= wdata[NIO-1:0];
        end
    end
endmodule

// File: rtl/line_irq_ctrl.sv
module line_irq_ctrl
    import lirq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int NIO = 4,
    parameter int AW  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCH-1:0]     st_hook,
    input  logic [NCH-1:0]     st_rtrip,
    input  logic [NCH-1:0]     st_gkey,
    input  logic [NCH-1:0]     st_gpol,
    input  logic [NCH-1:0]     st_otemp,
    input  logic [NCH-1:0]     st_ramp,
    input  logic [NCH-1:0]     st_tone,
    input  logic [NCH-1:0]     st_lvl,
    input  logic [NCH*NIO-1:0] st_io,
    input  logic [NCH*NIO-1:0] io_is_in,
    input  logic [NCH-1:0]     ch_srst,
    input  logic [AW-1:0]      bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    output logic               bus_rvalid,
    output logic               irq_pin
);
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [AW-1:0] CH_LO = AW'(CH_BASE);
    localparam logic [AW-1:0] CH_HI = AW'(CH_BASE + 4 * NCH);

    logic [2*NCH-1:0] gpend;
    logic [NCH-1:0]   ev_hk_v, ev_gk_v, ev_loc_v, irq_loc_v, g_irq_v;
    logic             cfg_pol;
    logic             in_ch, hit_g, hit_cfg, clr_g;
    logic [AW-1:0]    ch_off;
    logic [CHW-1:0]   ch_sel;
    logic [1:0]       sub;
    logic [DW-1:0]    rd_word;
    logic             pend_any, ev_any, irq_act;

    logic [NEV-1:0] lp_ev_a   [NCH];
    logic [NEV-1:0] mask_ev_a [NCH];
    logic [NIO-1:0] lp_io_a   [NCH];
    logic [NIO-1:0] mask_io_a [NCH];
    logic [NCH*(NEV+NIO)-1:0] lp_flat;

    assign hit_g   = (bus_addr == AW'(A_GPEND));
    assign hit_cfg = (bus_addr == AW'(A_CFG));
    assign in_ch   = (bus_addr >= CH_LO) && (bus_addr < CH_HI);
    assign ch_off  = bus_addr - CH_LO;
    assign ch_sel  = ch_off[CHW+1:2];
    assign sub     = ch_off[1:0];
    assign clr_g   = bus_wr && hit_g;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic sel;
        assign sel = in_ch && (ch_sel == CHW'(c));
        lirq_chan #(.NIO(NIO)) i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .srst     (ch_srst[c]),
            .clr_all  (clr_g),
            .s_hook   (st_hook[c]),
            .s_rtrip  (st_rtrip[c]),
            .s_gkey   (st_gkey[c]),
            .s_gpol   (st_gpol[c]),
            .s_otemp  (st_otemp[c]),
            .s_ramp   (st_ramp[c]),
            .s_tone   (st_tone[c]),
            .s_lvl    (st_lvl[c]),
            .s_io     (st_io[c*NIO +: NIO]),
            .io_in    (io_is_in[c*NIO +: NIO]),
            .rdclr_ev (bus_rd && sel && sub == 2'd0),
            .rdclr_io (bus_rd && sel && sub == 2'd1),
            .wr_mev   (bus_wr && sel && sub == 2'd2),
            .wr_mio   (bus_wr && sel && sub == 2'd3),
            .wdata    (bus_wdata),
            .ev_hk    (ev_hk_v[c]),
            .ev_gk    (ev_gk_v[c]),
            .ev_loc   (ev_loc_v[c]),
            .lp_ev    (lp_ev_a[c]),
            .mask_ev  (mask_ev_a[c]),
            .lp_io    (lp_io_a[c]),
            .mask_io  (mask_io_a[c]),
            .irq_loc  (irq_loc_v[c])
        );
        assign g_irq_v[c] = (gpend[c] && !mask_ev_a[c][0]) ||
                            (gpend[NCH+c] && !mask_ev_a[c][1]);
        assign lp_flat[c*(NEV+NIO) +: NEV+NIO] = {lp_io_a[c], lp_ev_a[c]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gpend   <= '0;
            cfg_pol <= 1'b0;
        end else begin
            gpend <= (gpend & ~{2*NCH{clr_g || (bus_rd && hit_g)}}) | {ev_gk_v, ev_hk_v};
            if (bus_wr && hit_cfg) cfg_pol <= bus_wdata[0];
        end
    end

    always_comb begin
        rd_word = '0;
        if (hit_g) begin
            rd_word[2*NCH-1:0] = gpend;
        end else if (hit_cfg) begin
            rd_word[0] = cfg_pol;
        end else if (in_ch) begin
            unique case (sub)
                2'd0: rd_word[NEV-1:0] = lp_ev_a[ch_sel];
                2'd1: rd_word[NIO-1:0] = lp_io_a[ch_sel];
                2'd2: rd_word[NEV-1:0] = mask_ev_a[ch_sel];
                2'd3: rd_word[NIO-1:0] = mask_io_a[ch_sel];
            endcase
        end
    end

    lirq_bus_fsm i_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (bus_rd),
        .rd_word  (rd_word),
        .rd_data  (bus_rdata),
        .rd_valid (bus_rvalid)
    );

    assign irq_act  = (|g_irq_v) || (|irq_loc_v);
    assign irq_pin  = cfg_pol ? irq_act : !irq_act;
    assign pend_any = (|gpend) || (|lp_flat);
    assign ev_any   = (|ev_hk_v) || (|ev_gk_v) || (|ev_loc_v);
endmodule

// File: rtl/lirq_chk.sv
module lirq_chk #(
    parameter int NCH = 4,
    parameter int NIO = 4,
    parameter int AW  = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_rd,
    input logic                     bus_wr,
    input logic [AW-1:0]            bus_addr,
    input logic                     bus_rvalid,
    input logic [NCH-1:0]           ch_srst,
    input logic                     irq_pin,
    input logic                     cfg_pol,
    input logic                     pend_any,
    input logic                     ev_any,
    input logic [NCH*(5+NIO)-1:0]   lp_flat
);
    a_r7_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    a_r7_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    a_r8_write_clears_all: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == '0 && !ev_any) |=> !pend_any);

    a_r6_idle_pin_level: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_any |-> (irq_pin == !cfg_pol));

    for (genvar c = 0; c < NCH; c++) begin : g_srst
        a_r9_soft_clears_local: assert property (@(posedge clk) disable iff (!rst_n)
            ch_srst[c] |=> (lp_flat[c*(5+NIO) +: 5+NIO] == '0));
    end
endmodule

bind line_irq_ctrl lirq_chk #(.NCH(NCH), .NIO(NIO), .AW(AW)) i_lirq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rvalid (bus_rvalid),
    .ch_srst    (ch_srst),
    .irq_pin    (irq_pin),
    .cfg_pol    (cfg_pol),
    .pend_any   (pend_any),
    .ev_any     (ev_any),
    .lp_flat    (lp_flat)
);

// File: tb/test_line_irq_ctrl.sv
module test_line_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  st_hook = 4'b1000, st_rtrip = '0, st_gkey = '0, st_gpol = '0;
    logic [3:0]  st_otemp = 4'b0010, st_ramp = '0, st_tone = '0, st_lvl = '0;
    logic [15:0] st_io = '0;
    logic [15:0] io_is_in = 16'hBFFF;   // channel 3 IO bit 2 is an output
    logic [3:0]  ch_srst = '0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_rvalid, irq_pin;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] rd;
    logic       rv;

    always #4 clk = ~clk;

    line_irq_ctrl i_line_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .st_hook(st_hook), .st_rtrip(st_rtrip),
        .st_gkey(st_gkey), .st_gpol(st_gpol), .st_otemp(st_otemp),
        .st_ramp(st_ramp), .st_tone(st_tone), .st_lvl(st_lvl),
        .st_io(st_io), .io_is_in(io_is_in), .ch_srst(ch_srst),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq_pin(irq_pin)
    );

    // {src[4], ch[2], val, pad, addr[8], pad[8], expect[8]}
    localparam logic [31:0] VEC [17] = '{
        {4'd0, 2'd0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h01},
        {4'd0, 2'd0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h01},
        {4'd1, 2'd2, 1'b1, 1'b0, 8'h00, 8'h00, 8'h04},
        {4'd2, 2'd1, 1'b1, 1'b0, 8'h00, 8'h00, 8'h20},
        {4'd2, 2'd1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h20},
        {4'd3, 2'd3, 1'b1, 1'b0, 8'h1C, 8'h00, 8'h01},
        {4'd3, 2'd3, 1'b0, 1'b0, 8'h1C, 8'h00, 8'h01},
        {4'd4, 2'd0, 1'b1, 1'b0, 8'h10, 8'h00, 8'h02},
        {4'd4, 2'd0, 1'b0, 1'b0, 8'h10, 8'h00, 8'h00},
        {4'd5, 2'd1, 1'b1, 1'b0, 8'h14, 8'h00, 8'h04},
        {4'd6, 2'd2, 1'b1, 1'b0, 8'h18, 8'h00, 8'h08},
        {4'd7, 2'd2, 1'b1, 1'b0, 8'h18, 8'h00, 8'h10},
        {4'd7, 2'd2, 1'b0, 1'b0, 8'h18, 8'h00, 8'h00},
        {4'd9, 2'd1, 1'b1, 1'b0, 8'h15, 8'h00, 8'h02},
        {4'd9, 2'd1, 1'b0, 1'b0, 8'h15, 8'h00, 8'h02},
        {4'd10, 2'd3, 1'b1, 1'b0, 8'h1D, 8'h00, 8'h00},
        {4'd8, 2'd3, 1'b1, 1'b0, 8'h1D, 8'h00, 8'h01}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [5:0] a, output logic [7:0] d, output logic v);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
        v = bus_rvalid;
    endtask

    task automatic do_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic set_src(input int src, input int ch, input logic val);
        case (src)
            0: st_hook[ch]  = val;
            1: st_rtrip[ch] = val;
            2: st_gkey[ch]  = val;
            3: st_gpol[ch]  = val;
            4: st_otemp[ch] = val;
            5: st_ramp[ch]  = val;
            6: st_tone[ch]  = val;
            7: st_lvl[ch]   = val;
            default: st_io[ch*4 + (src - 8)] = val;
        endcase
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pin", {7'd0, irq_pin}, 8'h01);
        check("R1 rvalid", {7'd0, bus_rvalid}, 8'h00);
        do_read(6'h12, rd, rv); check("R1 event mask", rd, 8'h1F);
        do_read(6'h13, rd, rv); check("R1 io mask", rd, 8'h0F);
        do_read(6'h01, rd, rv); check("R1 config", rd, 8'h00);
        // R10 levels high at reset release raise nothing
        do_read(6'h00, rd, rv); check("R10 global", rd, 8'h00);
        do_read(6'h14, rd, rv); check("R10 local ch1", rd, 8'h00);

        // table of source changes: R2 / R3 / R4
        for (int i = 0; i < 17; i++) begin
            int src, ch;
            src = int'(VEC[i][31:28]);
            ch  = int'(VEC[i][27:26]);
            @(negedge clk);
            set_src(src, ch, VEC[i][25]);
            do_read(VEC[i][21:16], rd, rv);
            check(src <= 2 ? "R2 global" : (src <= 7 ? "R3 local" : "R4 io"), rd, VEC[i][7:0]);
        end

        // R6 polarity, unmaskable tone source (R5)
        check("R6 idle low-active", {7'd0, irq_pin}, 8'h01);
        @(negedge clk); st_tone[0] = 1'b1;
        @(negedge clk); check("R5 tone unmaskable / R6 active low", {7'd0, irq_pin}, 8'h00);
        do_write(6'h01, 8'h01);
        check("R6 active high", {7'd0, irq_pin}, 8'h01);
        // R8 clear all
        do_write(6'h00, 8'h5A);
        check("R8 pin inactive", {7'd0, irq_pin}, 8'h00);
        do_read(6'h10, rd, rv); check("R8 local cleared", rd, 8'h00);

        // R5 masked source still recorded
        @(negedge clk); st_hook[0] = 1'b1;
        @(negedge clk); check("R5 masked pin", {7'd0, irq_pin}, 8'h00);
        do_write(6'h12, 8'h1E);
        check("R5 unmasked pin", {7'd0, irq_pin}, 8'h01);
        do_read(6'h00, rd, rv); check("R5 recorded", rd, 8'h01);
        check("R7 pin after read clear", {7'd0, irq_pin}, 8'h00);
        do_write(6'h12, 8'h1F);

        // R7 event in same cycle as clear-on-read survives
        @(negedge clk);
        st_gkey[0] = 1'b1;
        bus_addr   = 6'h00;
        bus_rd     = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check("R7 first read", bus_rdata, 8'h00);
        check("R7 rvalid", {7'd0, bus_rvalid}, 8'h01);
        do_read(6'h00, rd, rv); check("R7 event kept", rd, 8'h10);

        // R8 local clear by global write
        @(negedge clk); st_otemp[2] = 1'b1;
        do_write(6'h00, 8'h00);
        do_read(6'h18, rd, rv); check("R8 local ch2", rd, 8'h00);

        // R9 soft reset of channel 1 only
        @(negedge clk);
        st_ramp[1] = 1'b0;
        st_ramp[2] = 1'b1;
        st_gkey[1] = 1'b1;
        @(negedge clk); st_ramp[1] = 1'b1;
        @(negedge clk); ch_srst = 4'b0010;
        @(negedge clk); ch_srst = 4'b0000;
        do_read(6'h14, rd, rv); check("R9 ch1 cleared", rd, 8'h00);
        do_read(6'h18, rd, rv); check("R9 ch2 kept", rd, 8'h04);
        do_read(6'h00, rd, rv); check("R9 global kept", rd, 8'h20);
        do_read(6'h14, rd, rv); check("R9 no event after soft reset", rd, 8'h00);

        finish_run();
    end
endmodule